// File: doc/BRIEF.md
# Audio Interface Clock Generator

This block turns a system clock that runs at 768 times the audio sample rate into the clocks a serial audio link and its converters need. It always produces a converter master clock. After reset that clock is the system clock divided by three (256fs). A two-bit rate select can change it to half the system clock (384fs), to the system clock itself (768fs), or stop it low. Divided rates have a 50% duty cycle, and a rate change takes effect only while the output is low, so no short pulse ever appears.

When the block is the timing master, it generates a frame (LR) clock at the sample rate and a bit clock at 64fs or 32fs. Every LR transition falls on a falling edge of the bit clock. When the block is a slave, the bit and LR clocks from the external master pass straight through to the outputs, and the master clock keeps running.

Top module: `audio_clkgen`

## Requirements
- R1: While `rst_n` is low, `mclk_out`, `bclk_out` and `lrclk_out` are low (master mode). After release, `mclk_out` runs at one third of `clk`, giving 8 rising edges in 24 system clocks, until another rate is requested.
- R2: `mclk_rate` encoding: 0 = clk/3, 1 = clk/2, 2 = clk passed through, 3 = stopped. Over 24 system clocks these give 8, 12, 24 and 0 rising edges.
- R3: With rate 3 selected, `mclk_out` stays low.
- R4: At rates 0, 1 and 2, `mclk_out` is high for exactly half the time (24 of 48 half-period samples over 24 clocks).
- R5: A new rate takes effect within 8 system clocks, and only while `mclk_out` is low. No high or low pulse of `mclk_out` is shorter than half a system clock period.
- R6: `mclk_out` runs at the selected rate in slave mode as well.
- R7: In master mode the LR period is 768 system clocks, with 384 low and 384 high. After reset LR starts low and first rises 384 clocks after release.
- R8: `bclk_fast` = 1 selects 64 bit-clock periods per frame (period 12 clocks); 0 selects 32 (period 24 clocks). The select is taken only when LR falls (at a frame boundary). After reset the rate is 64fs.
- R9: Every LR transition coincides with a falling bit-clock edge. After reset the bit clock first rises 6 clocks after release.
- R10: In slave mode (`master_en` = 0), `bclk_out` equals `bclk_in` and `lrclk_out` equals `lrclk_in`, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 768 times the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | 1: generate bit/LR clocks; 0: pass external ones through |
| bclk_fast | input | 1 | Bit clock rate: 1 = 64fs, 0 = 32fs |
| mclk_rate | input | 2 | Master clock rate select (see R2) |
| bclk_in | input | 1 | External bit clock (slave mode) |
| lrclk_in | input | 1 | External LR clock (slave mode) |
| mclk_out | output | 1 | Converter master clock |
| bclk_out | output | 1 | Bit clock output |
| lrclk_out | output | 1 | LR clock output |

## Verification
The bit and LR clocks come from registers updated on the rising system-clock edge. The bench therefore samples them 2 ns after each rising edge and counts edges from reset release: the first bit-clock rise is due on the 6th edge and the first LR rise on the 384th. A rate change on `mclk_out` is resolved at a falling edge within 8 clocks. Each vector waits 10 clocks before a 24-clock window in which rising edges are counted and the level is sampled 2 ns after both clock edges. A pulse-width monitor timestamps every `mclk_out` edge across all the switches. The slave path is combinational, so it is checked 1 ns after the inputs are driven.

// File: rtl/audio_clkgen.sv
`timescale 1ns/1ps
module audio_clkgen #(
  parameter int RATIO = 768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       master_en,
  input  logic       bclk_fast,
  input  logic [1:0] mclk_rate,
  input  logic       bclk_in,
  input  logic       lrclk_in,
  output logic       mclk_out,
  output logic       bclk_out,
  output logic       lrclk_out
);
  localparam logic [1:0] M_DIV3 = 2'd0;
  localparam logic [1:0] M_DIV2 = 2'd1;
  localparam logic [1:0] M_PASS = 2'd2;
  localparam logic [1:0] M_STOP = 2'd3;
  localparam int HALF_FAST = RATIO / 128;
  localparam int HALF_SLOW = RATIO / 64;
  localparam int CW = $clog2(2 * HALF_SLOW);

  // master clock dividers
  logic [2:0] ring;
  logic       ring_neg;
  logic       tog;
  logic [1:0] cur_rate;
  logic       cur_low, req_low;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ring <= 3'b100;
      tog  <= 1'b0;
    end else begin
      ring <= {ring[1:0], ring[2]};
      tog  <= ~tog;
    end

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) ring_neg <= 1'b0;
    else        ring_neg <= ring[0];

  always_comb begin
    case (cur_rate)
      M_DIV3:  cur_low = ring[2];
      M_DIV2:  cur_low = ~tog;
      default: cur_low = 1'b1;
    endcase
    case (mclk_rate)
      M_DIV3:  req_low = ring[2];
      M_DIV2:  req_low = ~tog;
      default: req_low = 1'b1;
    endcase
  end

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n)
      cur_rate <= M_DIV3;
    else if (mclk_rate != cur_rate && cur_low && req_low)
      cur_rate <= mclk_rate;

  always_comb
    case (cur_rate)
      M_DIV3:  mclk_out = ring[0] | ring_neg;
      M_DIV2:  mclk_out = tog;
      M_PASS:  mclk_out = clk;
      default: mclk_out = 1'b0;
    endcase

  p_stop_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_rate == M_STOP) |-> !mclk_out);

  p_div2_alt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_rate == M_DIV2 && $past(cur_rate) == M_DIV2) |-> (mclk_out != $past(mclk_out)));

  p_switch_low_r5: assert property (@(negedge clk) disable iff (!rst_n)
    (cur_rate != M_PASS && mclk_out) |=> (cur_rate == $past(cur_rate)));

  // bit and frame clocks
  logic          fast_q;
  logic [CW-1:0] div_cnt;
  logic [5:0]    bit_cnt;
  logic          bclk_q, lrclk_q;

  wire [CW-1:0] div_last = fast_q ? CW'(2 * HALF_FAST - 1) : CW'(2 * HALF_SLOW - 1);
  wire [CW-1:0] div_mid  = fast_q ? CW'(HALF_FAST - 1)     : CW'(HALF_SLOW - 1);
  wire [5:0]    bit_last = fast_q ? 6'd63 : 6'd31;
  wire [5:0]    bit_mid  = fast_q ? 6'd31 : 6'd15;
  wire          div_wrap = (div_cnt == div_last);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fast_q  <= 1'b1;
      div_cnt <= '0;
      bit_cnt <= '0;
      bclk_q  <= 1'b0;
      lrclk_q <= 1'b0;
    end else begin
      div_cnt <= div_wrap ? '0 : div_cnt + 1'b1;
      if (div_wrap)
        bit_cnt <= (bit_cnt == bit_last) ? '0 : bit_cnt + 1'b1;
      if (div_wrap || div_cnt == div_mid)
        bclk_q <= ~bclk_q;
      if (div_wrap && (bit_cnt == bit_mid || bit_cnt == bit_last))
        lrclk_q <= ~lrclk_q;
      if (div_wrap && bit_cnt == bit_last)
        fast_q <= bclk_fast;
    end

  assign bclk_out  = master_en ? bclk_q  : bclk_in;
  assign lrclk_out = master_en ? lrclk_q : lrclk_in;

  p_lr_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lrclk_q != $past(lrclk_q)) |-> (!bclk_q && $past(bclk_q)));

  p_rate_at_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_q != $past(fast_q)) |-> (!lrclk_q && $past(lrclk_q)));
endmodule

// File: tb/audio_clkgen_bench.sv
`timescale 1ns/1ps
module audio_clkgen_bench;
  logic clk = 1'b0;
  logic rst_n, master_en, bclk_fast, bclk_in, lrclk_in;
  logic [1:0] mclk_rate;
  logic mclk_out, bclk_out, lrclk_out;

  audio_clkgen u_audio_clkgen (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .bclk_fast(bclk_fast),
    .mclk_rate(mclk_rate), .bclk_in(bclk_in), .lrclk_in(lrclk_in),
    .mclk_out(mclk_out), .bclk_out(bclk_out), .lrclk_out(lrclk_out));

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  int mck_rises = 0, bck_rises = 0, short_cnt = 0;
  bit mon_en = 0;
  realtime t_up = 0, t_dn = 0;

  localparam int NV = 8;
  localparam logic [1:0] VSEL  [NV] = '{2'd1, 2'd2, 2'd3, 2'd0, 2'd2, 2'd1, 2'd3, 2'd2};
  localparam int         VRISE [NV] = '{12, 24, 0, 8, 24, 12, 0, 24};
  localparam int         VHIGH [NV] = '{24, 24, 0, 24, 24, 24, 0, 24};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge mclk_out) begin
    mck_rises++;
    if (mon_en && ($realtime - t_dn) < 3.5) short_cnt++;
    t_up = $realtime;
  end
  always @(negedge mclk_out) begin
    if (mon_en && ($realtime - t_up) < 3.5) short_cnt++;
    t_dn = $realtime;
  end
  always @(posedge bclk_out) bck_rises++;

  task automatic measure(output int rises, output int highs);
    highs = 0;
    @(posedge clk); #2;
    mck_rises = 0;
    repeat (24) begin
      @(negedge clk); #2 highs += int'(mclk_out);
      @(posedge clk); #2 highs += int'(mclk_out);
    end
    rises = mck_rises;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int first_bck, first_lr, r24, cyc, low_at, r, h;
    rst_n = 0; master_en = 1; bclk_fast = 1; mclk_rate = 2'd0;
    bclk_in = 0; lrclk_in = 0;
    repeat (4) @(posedge clk);
    #2;
    chk(mclk_out == 0, "R1 mclk in reset", int'(mclk_out), 0);
    chk(bclk_out == 0, "R1 bclk in reset", int'(bclk_out), 0);
    chk(lrclk_out == 0, "R1 lrclk in reset", int'(lrclk_out), 0);
    @(negedge clk); #2;
    chk(mclk_out == 0, "R1 mclk in reset low phase", int'(mclk_out), 0);

    @(posedge clk); #2;
    rst_n = 1; mon_en = 1; mck_rises = 0;
    first_bck = 0; first_lr = 0; r24 = 0;
    for (int k = 1; k <= 400; k++) begin
      @(posedge clk); #2;
      if (bclk_out && first_bck == 0) first_bck = k;
      if (k == 24) r24 = mck_rises;
      if (lrclk_out && first_lr == 0) first_lr = k;
      if (first_lr != 0) break;
    end
    chk(r24 == 8, "R1 default clk/3 after reset", r24, 8);
    chk(first_bck == 6, "R9 first bit clock rise", first_bck, 6);
    chk(first_lr == 384, "R7 first LR rise", first_lr, 384);

    bck_rises = 0; cyc = 0; low_at = 0;
    for (int k = 0; k < 2000; k++) begin
      @(posedge clk); #2;
      cyc++;
      if (!lrclk_out && low_at == 0) low_at = cyc;
      if (lrclk_out && low_at != 0) break;
    end
    chk(low_at == 384, "R7 LR high length", low_at, 384);
    chk(cyc == 768, "R7 LR period", cyc, 768);
    chk(bck_rises == 64, "R8 bit clocks per frame at 64fs", bck_rises, 64);

    for (int i = 0; i < NV; i++) begin
      @(posedge clk); #2 mclk_rate = VSEL[i];
      repeat (10) @(posedge clk);
      measure(r, h);
      chk(r == VRISE[i], "R2 mclk rising edges", r, VRISE[i]);
      chk(h == VHIGH[i], (VSEL[i] == 2'd3) ? "R3 stopped mclk high samples" : "R4 mclk duty samples", h, VHIGH[i]);
    end
    chk(short_cnt == 0, "R5 short mclk pulses", short_cnt, 0);

    @(negedge lrclk_out); #1 bclk_fast = 0; bck_rises = 0;
    @(negedge lrclk_out); #1;
    chk(bck_rises == 64, "R8 frame in progress keeps 64fs", bck_rises, 64);
    bck_rises = 0;
    @(negedge lrclk_out); #1;
    chk(bck_rises == 32, "R8 next frame at 32fs", bck_rises, 32);

    @(posedge clk); #2;
    master_en = 0; mclk_rate = 2'd1;
    for (int p = 0; p < 4; p++) begin
      bclk_in = p[0]; lrclk_in = p[1];
      #1;
      chk(bclk_out == bclk_in, "R10 slave bit clock copy", int'(bclk_out), int'(bclk_in));
      chk(lrclk_out == lrclk_in, "R10 slave LR copy", int'(lrclk_out), int'(lrclk_in));
      @(posedge clk); #2;
    end
    repeat (10) @(posedge clk);
    measure(r, h);
    chk(r == 12, "R6 mclk runs in slave mode", r, 12);
    chk(short_cnt == 0, "R5 short mclk pulses overall", short_cnt, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule